// File: doc/BRIEF.md
# Half-Bridge Interlock and Dead-Time Unit

This block turns one phase's pair of switch commands into a pair of gate enables that can never be on together. Both commands are active low, and each one is cleaned by a short-pulse filter before it is used. An enable input passes through the same kind of filter. When the two commands overlap, the side that asked first keeps its gate and the other side is held off. Every handover from one side to the other is separated by a minimum dead time. That time is added only when the commands themselves leave a smaller gap.

An inverter uses three instances, one per phase. The fault controller drives a shutdown input that clears both gates in the same cycle, whatever state the interlock is in. Every time is a count of clock cycles, set by a parameter: `FILT_CYC` for the filters and `DEAD_CYC` for the dead time.

Top module: `phase_gate_guard`

## Requirements
- R1: A command input held low turns its gate on, and a command held high keeps it off. A gate rises exactly FILT_CYC+2 clock edges after the edge that first samples its command low, provided no interlock or dead-time rule holds it back.
- R2: `gate_hi` and `gate_lo` are never both 1 in the same cycle.
- R3: While one side's gate is on and its command stays low, asserting the other command leaves that gate on and keeps the other gate off.
- R4: If both commands are first sampled low on the same edge while neither side owns the phase, the low-side gate turns on and the high-side gate stays off.
- R5: From the cycle one gate turns off, the opposite gate stays off for at least DEAD_CYC cycles.
- R6: If the gap between one command releasing and the opposite command asserting is G cycles, the opposite gate rises max(G, DEAD_CYC) cycles after the first gate falls. A gap of at least DEAD_CYC therefore passes through unchanged.
- R7: A pulse on a command or enable input that lasts fewer than FILT_CYC cycles changes no output. This holds for on-pulses and for off-pulses.
- R8: A command pulse of W >= FILT_CYC cycles gives a gate pulse of exactly W cycles, so both edges see the same delay.
- R9: `enable` low for at least FILT_CYC cycles turns both gates off FILT_CYC+1 edges after the first low sample. A gate that is on stays on until that edge.
- R10: `kill` high forces both gates to 0 in the same cycle, without waiting for a clock edge.
- R11: A gate that was blocked by the interlock turns on once the blocking command releases, but only if its own command is still low. It then rises DEAD_CYC cycles after the blocking gate falls.
- R12: Both gates are 0 during reset and right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd_n | input | 1 | High-side switch command, active low, synchronous to clk |
| lo_cmd_n | input | 1 | Low-side switch command, active low, synchronous to clk |
| enable | input | 1 | Filtered run enable; low turns both gates off |
| kill | input | 1 | Immediate shutdown from the fault controller |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |

## Verification
A wrong filter count shows up as a gate edge that is one or more cycles early or late. It can also show as a gate pulse whose width differs from the command width, and this is visible within FILT_CYC+2 cycles of the input edge. A wrong owner register shows up as the wrong side winning a tie or an overlap, or as a blocked side switching on after its command is gone. A miscounted dead-time counter moves the rising edge of the opposite gate away from max(G, DEAD_CYC) after the falling edge, which sweeps over the command gap expose within one handover.

// File: rtl/pgg_pkg.sv
// Package for the phase gate guard: the type that names which side of the
// phase owns it, or last switched off.
package pgg_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;
endpackage

// File: rtl/pgg_filter.sv
// Short-pulse filter. The output takes the input's level only after the input
// has differed from the output for CYC consecutive samples, so rising and
// falling edges get the same delay of CYC edges. Assumes din is already
// synchronous to clk and that CYC >= 2.
module pgg_filter #(
    parameter int   CYC     = 31,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(CYC);

    logic [CW-1:0] run_q;
    logic          lvl_q;

    // Count consecutive samples that disagree with the output; flip on the CYC-th.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= RST_VAL;
            run_q <= '0;
        end else if (din != lvl_q) begin
            if (run_q == CW'(CYC - 1)) begin
                lvl_q <= din;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign dout = lvl_q;

    // R7: the output only moves toward a level the input held on the previous sample.
    assert_follow_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(din)));
endmodule

// File: rtl/pgg_arbiter.sv
// Interlock arbiter. It takes active-high filtered requests and grants at most
// one side. The owner keeps the phase while its request holds. On a tie from
// idle the low side wins. When the owner releases, the other side is granted
// only if it is still requesting.
module pgg_arbiter
    import pgg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_hi,
    input  logic req_lo,
    output logic grant_hi,
    output logic grant_lo
);
    side_e owner_q, owner_d;

    // Choose the next owner from the current owner and the live requests.
    always_comb begin
        owner_d = owner_q;
        unique case (owner_q)
            SIDE_HI: owner_d = req_hi ? SIDE_HI : (req_lo ? SIDE_LO : SIDE_NONE);
            SIDE_LO: owner_d = req_lo ? SIDE_LO : (req_hi ? SIDE_HI : SIDE_NONE);
            default: owner_d = req_lo ? SIDE_LO : (req_hi ? SIDE_HI : SIDE_NONE);
        endcase
    end

    // Hold the owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= SIDE_NONE;
        else        owner_q <= owner_d;
    end

    assign grant_hi = (owner_q == SIDE_HI);
    assign grant_lo = (owner_q == SIDE_LO);

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_hi, grant_lo}));
    assert_first_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_hi && req_hi) |=> grant_hi);
    assert_first_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_lo && req_lo) |=> grant_lo);
    assert_tie_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_hi && !grant_lo && req_hi && req_lo) |=> grant_lo);
endmodule

// File: rtl/pgg_deadtime.sv
// Dead-time stage. It registers the two gates from the arbiter grants. A gate
// may rise only when the opposite gate is off and, if the opposite side was
// the last to switch off, at least DEAD_CYC cycles have passed since then.
// The stage assumes the grants are mutually exclusive. run low clears both
// gates on the next edge.
module pgg_deadtime
    import pgg_pkg::*;
#(
    parameter int DEAD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi,
    input  logic want_lo,
    input  logic run,
    output logic gate_hi_q,
    output logic gate_lo_q
);
    localparam int GW = $clog2(DEAD_CYC + 1);

    logic [GW-1:0] gap_q;
    side_e         last_off_q;
    logic          hi_d, lo_d, hi_ok, lo_ok;

    // Decide whether each side may be on next cycle.
    always_comb begin
        hi_ok = want_hi && !gate_lo_q &&
                !((last_off_q == SIDE_LO) && (gap_q < GW'(DEAD_CYC)));
        lo_ok = want_lo && !gate_hi_q &&
                !((last_off_q == SIDE_HI) && (gap_q < GW'(DEAD_CYC)));
        hi_d  = run && hi_ok;
        lo_d  = run && lo_ok;
    end

    // Register the gates, and restart the gap count whenever a gate switches off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_hi_q  <= 1'b0;
            gate_lo_q  <= 1'b0;
            gap_q      <= GW'(DEAD_CYC);
            last_off_q <= SIDE_NONE;
        end else begin
            gate_hi_q <= hi_d;
            gate_lo_q <= lo_d;
            if (gate_hi_q && !hi_d) begin
                last_off_q <= SIDE_HI;
                gap_q      <= GW'(1);
            end else if (gate_lo_q && !lo_d) begin
                last_off_q <= SIDE_LO;
                gap_q      <= GW'(1);
            end else if (gap_q != GW'(DEAD_CYC)) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // Checker: cycles since each gate was last on, saturating at DEAD_CYC.
    logic [GW-1:0] hi_age_q, lo_age_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_age_q <= GW'(DEAD_CYC);
            lo_age_q <= GW'(DEAD_CYC);
        end else begin
            hi_age_q <= gate_hi_q ? '0 : ((hi_age_q == GW'(DEAD_CYC)) ? hi_age_q : hi_age_q + 1'b1);
            lo_age_q <= gate_lo_q ? '0 : ((lo_age_q == GW'(DEAD_CYC)) ? lo_age_q : lo_age_q + 1'b1);
        end
    end

    assert_dead_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_hi_q) |-> (lo_age_q >= GW'(DEAD_CYC)));
    assert_dead_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_lo_q) |-> (hi_age_q >= GW'(DEAD_CYC)));
    assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi_q && gate_lo_q));
endmodule

// File: rtl/phase_gate_guard.sv
// One phase of a half-bridge gate guard. It filters the two active-low
// commands and the enable, then arbitrates the overlap, inserts the dead time
// and gates the result with the immediate kill input. Assumes all inputs are
// synchronous to clk. Instantiate once per phase.
module phase_gate_guard #(
    parameter int FILT_CYC = 31,
    parameter int DEAD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd_n,
    input  logic lo_cmd_n,
    input  logic enable,
    input  logic kill,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int         NIN      = 3;
    localparam logic [2:0] IDLE_LVL = 3'b011;   // enable idles low, commands idle high

    logic [NIN-1:0] raw, clean;
    logic           grant_hi, grant_lo, hi_q, lo_q;

    assign raw = {enable, lo_cmd_n, hi_cmd_n};

    // One short-pulse filter per input.
    for (genvar i = 0; i < NIN; i++) begin : g_filt
        pgg_filter #(
            .CYC     (FILT_CYC),
            .RST_VAL (IDLE_LVL[i])
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (raw[i]),
            .dout  (clean[i])
        );
    end

    pgg_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_hi   (~clean[0]),
        .req_lo   (~clean[1]),
        .grant_hi (grant_hi),
        .grant_lo (grant_lo)
    );

    pgg_deadtime #(
        .DEAD_CYC (DEAD_CYC)
    ) u_dt (
        .clk       (clk),
        .rst_n     (rst_n),
        .want_hi   (grant_hi),
        .want_lo   (grant_lo),
        .run       (clean[2] && !kill),
        .gate_hi_q (hi_q),
        .gate_lo_q (lo_q)
    );

    // Kill acts at once, ahead of the registered gates.
    assign gate_hi = hi_q && !kill;
    assign gate_lo = lo_q && !kill;

    assert_never_both_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_hi && gate_lo));
    assert_kill_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !(hi_q || lo_q));
    assert_reset_off_R12: assert property (@(posedge clk)
        $past(!rst_n) |-> !(gate_hi || gate_lo));
endmodule

// File: tb/phase_gate_guard_bench.sv
`timescale 1ns/1ps
module phase_gate_guard_bench;
    localparam int FILT = 4;
    localparam int DT   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_n = 1'b1, lo_n = 1'b1, en = 1'b1, kill = 1'b0;
    logic gate_hi, gate_lo;
    int   n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    phase_gate_guard #(.FILT_CYC(FILT), .DEAD_CYC(DT)) u_phase_gate_guard (
        .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_n), .lo_cmd_n(lo_n),
        .enable(en), .kill(kill), .gate_hi(gate_hi), .gate_lo(gate_lo)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        @(negedge clk);
        hi_n = 1'b1; lo_n = 1'b1; en = 1'b1; kill = 1'b0;
        wait_n(FILT + DT + 10);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int first, cnt, fall, rise, exp;
        bit both;
        // R12: reset state
        wait_n(3);
        chk(!gate_hi && !gate_lo, "R12 in reset", int'({gate_hi, gate_lo}), 0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(FILT + 4);
        chk(!gate_hi && !gate_lo, "R12 after reset", int'({gate_hi, gate_lo}), 0);

        // R1/R7/R8: on-pulse width sweep on each side
        for (int side = 0; side < 2; side++) begin
            for (int w = 1; w <= 8; w++) begin
                first = -1; cnt = 0;
                for (int k = 0; k < w + FILT + 10; k++) begin
                    @(negedge clk);
                    if ((side ? gate_hi : gate_lo)) begin
                        cnt++;
                        if (first < 0) first = k;
                    end
                    if (side) hi_n = (k < w) ? 1'b0 : 1'b1;
                    else      lo_n = (k < w) ? 1'b0 : 1'b1;
                end
                if (w < FILT) chk(cnt == 0, "R7 short on-pulse", cnt, 0);
                else begin
                    chk(cnt == w, "R8 width kept", cnt, w);
                    chk(first == FILT + 2, "R1 latency", first, FILT + 2);
                end
                settle();
            end
        end

        // R7/R8: off-pulse sweep on a held low-side command
        for (int w = 1; w <= 8; w++) begin
            @(negedge clk); lo_n = 1'b0;
            wait_n(FILT + 4);
            cnt = 0;
            for (int k = 0; k < w + FILT + 10; k++) begin
                @(negedge clk);
                if (!gate_lo) cnt++;
                lo_n = (k < w) ? 1'b1 : 1'b0;
            end
            exp = (w < FILT) ? 0 : w;
            chk(cnt == exp, (w < FILT) ? "R7 short off-pulse" : "R8 off width", cnt, exp);
            settle();
        end

        // R5/R6/R11: gap sweep from low side to high side, G<0 is overlap
        for (int g = -3; g <= 10; g++) begin
            @(negedge clk); lo_n = 1'b0;
            wait_n(FILT + 4);
            fall = -1; rise = -1; both = 0;
            for (int k = -4; k < FILT + DT + 16; k++) begin
                @(negedge clk);
                if (gate_hi && gate_lo) both = 1;
                if (k >= 0 && !gate_lo && fall < 0) fall = k;
                if (gate_hi && rise < 0) rise = k;
                lo_n = (k >= 0) ? 1'b1 : 1'b0;
                hi_n = (k >= g) ? 1'b0 : 1'b1;
            end
            exp = (g > DT) ? g : DT;
            chk(!both, "R2 no overlap", int'(both), 0);
            chk(fall == FILT + 2, "R1 fall latency", fall, FILT + 2);
            if (g < 0) chk(rise - fall == exp, "R11 blocked side after release", rise - fall, exp);
            else if (g >= DT) chk(rise - fall == exp, "R6 external gap kept", rise - fall, exp);
            else chk(rise - fall == exp, "R5 dead time inserted", rise - fall, exp);
            settle();
        end

        // R3: high side first keeps its gate
        @(negedge clk); hi_n = 1'b0;
        wait_n(FILT + 4);
        @(negedge clk); lo_n = 1'b0;
        wait_n(FILT + 6);
        chk(gate_hi && !gate_lo, "R3 first keeps", int'({gate_hi, gate_lo}), 2);
        settle();

        // R4 then R11: tie from idle, low wins; release low, high follows
        @(negedge clk); hi_n = 1'b0; lo_n = 1'b0;
        wait_n(FILT + 4);
        chk(gate_lo && !gate_hi, "R4 tie low wins", int'({gate_hi, gate_lo}), 1);
        @(negedge clk); lo_n = 1'b1;
        wait_n(FILT + 2 + DT - 1);
        chk(!gate_hi && !gate_lo, "R11 still dead", int'({gate_hi, gate_lo}), 0);
        wait_n(1);
        chk(gate_hi && !gate_lo, "R11 blocked side on", int'({gate_hi, gate_lo}), 2);
        settle();

        // R11: blocked side with its command gone stays off
        @(negedge clk); lo_n = 1'b0;
        wait_n(FILT + 4);
        @(negedge clk); hi_n = 1'b0;
        wait_n(FILT + 4);
        @(negedge clk); hi_n = 1'b1;
        wait_n(FILT + 4);
        @(negedge clk); lo_n = 1'b1;
        cnt = 0;
        for (int k = 0; k < FILT + DT + 10; k++) begin
            @(negedge clk);
            if (gate_hi) cnt++;
        end
        chk(cnt == 0, "R11 no stale turn-on", cnt, 0);
        settle();

        // R9/R7: enable glitch ignored, long low turns gates off at FILT+1
        @(negedge clk); lo_n = 1'b0;
        wait_n(FILT + 4);
        cnt = 0;
        for (int k = 0; k < FILT + 6; k++) begin
            @(negedge clk);
            if (!gate_lo) cnt++;
            en = (k < FILT - 1) ? 1'b0 : 1'b1;
        end
        chk(cnt == 0, "R7 enable glitch", cnt, 0);
        first = -1;
        for (int k = 0; k < FILT + 6; k++) begin
            @(negedge clk);
            if (!gate_lo && first < 0) first = k;
            en = 1'b0;
        end
        chk(first == FILT + 1, "R9 enable off latency", first, FILT + 1);
        @(negedge clk); en = 1'b1;
        wait_n(FILT + 4);
        chk(gate_lo, "R9 enable restored", int'(gate_lo), 1);

        // R10: kill clears at once, without a clock edge
        @(negedge clk); kill = 1'b1;
        #1;
        chk(!gate_lo && !gate_hi, "R10 kill immediate", int'({gate_hi, gate_lo}), 0);
        wait_n(3);
        chk(!gate_lo, "R10 kill held", int'(gate_lo), 0);
        settle();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule